// File: doc/BRIEF.md
# Four-Lane Clock-Framed 7:1 Deserializer

This block turns four serial data lanes into one 28-bit parallel word per frame. A local sampling clock runs at seven times the frame rate. On each of its edges the block samples every data lane and a digital copy of the transmitter's frame clock. The frame clock is high for four sampling slots and low for three. The block searches that waveform for the frame boundary and holds lock on it. It collects seven bits per lane and scatters them onto a fixed output bit arrangement that is not contiguous.

A complete word is shown on the output together with a frame strobe that has the same 4/3 duty as the incoming frame clock. Words appear only while the framing is locked. An active-low shutdown input clears every register. After shutdown is released, framing must be found again before another word comes out.

Top module: `sevenx_deser_rx`

## Requirements
- R1: Within a frame the serial order of output bit positions is fixed per lane. Lane 0 sends 7,6,4,3,2,1,0. Lane 1 sends 18,15,14,13,12,9,8. Lane 2 sends 26,25,24,22,21,20,19. Lane 3 sends 27,23,17,16,11,10,5. Each list runs from the first sample to the last.
- R2: A frame is seven consecutive samples whose frame-clock values, oldest first, are 1,1,1,1,0,0,0. Slot 0 of a frame is the first sample in which the frame clock is high.
- R3: `locked_o` rises on the clock edge that samples the last slot of the second consecutive matching frame. The first word output is the data of that second frame.
- R4: While locked, a frame-clock window that fails to match at the expected frame end clears `locked_o` and `word_o` to zero on that edge. The block then restarts the search.
- R5: While `locked_o` is low, `word_o` is zero and `strobe_o` is low.
- R6: Each locked frame rises `strobe_o` on the edge that samples the frame's last slot, and `word_o` changes on that same edge. The strobe is high for 4 sampling cycles and low for 3, and the word holds for the whole following frame.
- R7: While `shdn_n` is low, every register is cleared. From the next edge on, `word_o`, `strobe_o` and `locked_o` are zero, whatever the lanes carry.
- R8: After `shdn_n` or `rst_n` is released, no word and no strobe appear until two full matching frames have been received. A partial frame never produces a word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_7x | input | 1 | Sampling clock at seven times the frame rate |
| rst_n | input | 1 | Synchronous active-low reset |
| shdn_n | input | 1 | Active-low shutdown; clears all state while low |
| fclk_i | input | 1 | Sampled frame clock (4 high / 3 low slots) |
| lane_i | input | 4 | Serial data lanes, one bit each per sample |
| word_o | output | 28 | Deserialized, scattered parallel word |
| strobe_o | output | 1 | Output frame strobe; rising edge marks a new word |
| locked_o | output | 1 | Frame alignment found and held |

## Verification
The bench uses the default parameters: four lanes, seven slots per frame and four high slots. With these values the full scattered map applies, so every output position can be reached by a walking-one word. The real 4/3 frame-clock duty is used as well, so a frame clock that is one slot short tests the loss of lock. The same values also let the bench release shutdown in the middle of a frame and check that the stray tail is never taken for a frame boundary.

// File: rtl/deser7_pkg.sv
// Package: shared types and the lane-to-output bit scatter map.
// Assumes the scatter map is only meaningful for 4 lanes x 7 bits; any
// other geometry falls back to a contiguous lane-major arrangement.
package deser7_pkg;

    typedef enum logic [1:0] {
        TRK_SEARCH = 2'd0,
        TRK_ONE    = 2'd1,
        TRK_LOCKED = 2'd2
    } trk_state_e;

    // Output position per lane, index 0 = last serial bit (5-bit fields, LSB first).
    localparam logic [34:0] MAP_L0 = {5'd7,  5'd6,  5'd4,  5'd3,  5'd2,  5'd1,  5'd0};
    localparam logic [34:0] MAP_L1 = {5'd18, 5'd15, 5'd14, 5'd13, 5'd12, 5'd9,  5'd8};
    localparam logic [34:0] MAP_L2 = {5'd26, 5'd25, 5'd24, 5'd22, 5'd21, 5'd20, 5'd19};
    localparam logic [34:0] MAP_L3 = {5'd27, 5'd23, 5'd17, 5'd16, 5'd11, 5'd10, 5'd5};

    // Returns the output bit fed by frame bit idx of a lane.
    function automatic int unsigned out_pos(input int unsigned lane,
                                            input int unsigned idx,
                                            input int unsigned bits,
                                            input int unsigned lanes);
        logic [34:0] tbl;
        if (bits != 7 || lanes != 4) begin
            return lane * bits + idx;
        end
        case (lane)
            0:       tbl = MAP_L0;
            1:       tbl = MAP_L1;
            2:       tbl = MAP_L2;
            default: tbl = MAP_L3;
        endcase
        return int'(tbl[idx*5 +: 5]);
    endfunction

endpackage

// File: rtl/frame_tracker.sv
// Frame tracker: watches the sampled frame clock for the high/low pattern,
// confirms it on two consecutive frames and then checks it at every
// expected frame end. Assumes one frame-clock sample per sampling edge.
module frame_tracker
    import deser7_pkg::*;
#(
    parameter int unsigned BITS     = 7,
    parameter int unsigned HI_SLOTS = 4
) (
    input  logic clk,
    input  logic clr_n,
    input  logic fclk_i,
    output logic load_o,
    output logic drop_o,
    output logic locked_o
);
    localparam int unsigned PH_W = (BITS > 2) ? $clog2(BITS) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(BITS - 1);
    localparam logic [BITS-1:0] PATTERN =
        BITS'(((1 << HI_SLOTS) - 1) << (BITS - HI_SLOTS));

    logic [BITS-2:0] hist_q;
    logic [BITS-1:0] window;
    logic            match;
    logic [PH_W-1:0] ph_q;
    trk_state_e      st_q;

    // Window of the last BITS samples, oldest at the MSB.
    assign window = {hist_q, fclk_i};
    assign match  = (window == PATTERN);

    // Frame end events at the expected slot.
    assign load_o = (st_q != TRK_SEARCH) && (ph_q == PH_LAST) && match;
    assign drop_o = (st_q != TRK_SEARCH) && (ph_q == PH_LAST) && !match;

    // History, search/lock state and phase within the frame.
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            hist_q   <= '0;
            st_q     <= TRK_SEARCH;
            ph_q     <= '0;
            locked_o <= 1'b0;
        end else begin
            hist_q <= window[BITS-2:0];
            case (st_q)
                TRK_SEARCH: begin
                    ph_q <= '0;
                    if (match) st_q <= TRK_ONE;
                end
                default: begin
                    if (ph_q == PH_LAST) begin
                        ph_q <= '0;
                        if (match) begin
                            st_q     <= TRK_LOCKED;
                            locked_o <= 1'b1;
                        end else begin
                            st_q     <= TRK_SEARCH;
                            locked_o <= 1'b0;
                        end
                    end else begin
                        ph_q <= ph_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // R3: lock only follows a frame already seen once
    p_lock_two_frames_r3: assert property (@(posedge clk) disable iff (!clr_n)
        $rose(locked_o) |-> $past(st_q == TRK_ONE));

    // R4: a missed frame end removes lock on the next edge
    p_drop_unlocks_r4: assert property (@(posedge clk) disable iff (!clr_n)
        drop_o |=> !locked_o);

endmodule

// File: rtl/lane_shifter.sv
// Lane shifter: one shift register per lane; the oldest sample ends up at
// the top of each lane's frame slice. Assumes the frame slice is read on
// the edge that samples the frame's last bit (current input included).
module lane_shifter #(
    parameter int unsigned LANES = 4,
    parameter int unsigned BITS  = 7
) (
    input  logic                  clk,
    input  logic                  clr_n,
    input  logic [LANES-1:0]      lane_i,
    output logic [LANES*BITS-1:0] frame_o
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [BITS-2:0] sh_q;

        // Shift one serial bit per sampling edge.
        always_ff @(posedge clk) begin
            if (!clr_n) sh_q <= '0;
            else        sh_q <= {sh_q[BITS-3:0], lane_i[l]};
        end

        assign frame_o[l*BITS +: BITS] = {sh_q, lane_i[l]};
    end

endmodule

// File: rtl/bit_scatter.sv
// Bit scatter: pure wiring from lane-major frame bits to the output bit
// arrangement given by the package map. Assumes the map is a permutation.
module bit_scatter
    import deser7_pkg::*;
#(
    parameter int unsigned LANES = 4,
    parameter int unsigned BITS  = 7
) (
    input  logic [LANES*BITS-1:0] frame_i,
    output logic [LANES*BITS-1:0] word_o
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        for (genvar j = 0; j < BITS; j++) begin : g_bit
            localparam int unsigned POS = out_pos(l, j, BITS, LANES);
            assign word_o[POS] = frame_i[l*BITS + j];
        end
    end

endmodule

// File: rtl/strobe_gen.sv
// Strobe generator: restarts a slot counter on every word load and drives
// the strobe high for the first HI_SLOTS slots. Assumes loads come at most
// once per BITS cycles.
module strobe_gen #(
    parameter int unsigned BITS     = 7,
    parameter int unsigned HI_SLOTS = 4
) (
    input  logic clk,
    input  logic clr_n,
    input  logic load_i,
    input  logic locked_i,
    output logic strobe_o
);
    localparam int unsigned CNT_W = (BITS > 2) ? $clog2(BITS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BITS - 1);
    localparam logic [CNT_W-1:0] CNT_HI   = CNT_W'(HI_SLOTS);

    logic [CNT_W-1:0] cnt_q;

    // Slot count since the last load, saturating at the last slot.
    always_ff @(posedge clk) begin
        if (!clr_n)                cnt_q <= CNT_LAST;
        else if (load_i)           cnt_q <= '0;
        else if (cnt_q != CNT_LAST) cnt_q <= cnt_q + 1'b1;
    end

    assign strobe_o = locked_i && (cnt_q < CNT_HI);

    // R6: every load is followed by a high strobe
    p_strobe_after_load_r6: assert property (@(posedge clk) disable iff (!clr_n)
        load_i |=> strobe_o);

endmodule

// File: rtl/sevenx_deser_rx.sv
// Top: four-lane 7:1 deserializer framed by a sampled 4/3 frame clock.
// Assumes clk_7x runs at seven times the frame rate and fclk_i, lane_i are
// already synchronous to it. Shutdown and reset both clear all state.
module sevenx_deser_rx
    import deser7_pkg::*;
#(
    parameter int unsigned LANES    = 4,
    parameter int unsigned BITS     = 7,
    parameter int unsigned HI_SLOTS = 4
) (
    input  logic                  clk_7x,
    input  logic                  rst_n,
    input  logic                  shdn_n,
    input  logic                  fclk_i,
    input  logic [LANES-1:0]      lane_i,
    output logic [LANES*BITS-1:0] word_o,
    output logic                  strobe_o,
    output logic                  locked_o
);
    localparam int unsigned W = LANES * BITS;

    logic         clr_n;
    logic         load;
    logic         drop;
    logic [W-1:0] frame;
    logic [W-1:0] scattered;

    assign clr_n = rst_n & shdn_n;

    frame_tracker #(.BITS(BITS), .HI_SLOTS(HI_SLOTS)) u_trk (
        .clk      (clk_7x),
        .clr_n    (clr_n),
        .fclk_i   (fclk_i),
        .load_o   (load),
        .drop_o   (drop),
        .locked_o (locked_o)
    );

    lane_shifter #(.LANES(LANES), .BITS(BITS)) u_shf (
        .clk     (clk_7x),
        .clr_n   (clr_n),
        .lane_i  (lane_i),
        .frame_o (frame)
    );

    bit_scatter #(.LANES(LANES), .BITS(BITS)) u_map (
        .frame_i (frame),
        .word_o  (scattered)
    );

    strobe_gen #(.BITS(BITS), .HI_SLOTS(HI_SLOTS)) u_stb (
        .clk      (clk_7x),
        .clr_n    (clr_n),
        .load_i   (load),
        .locked_i (locked_o),
        .strobe_o (strobe_o)
    );

    // Output word: loaded on a confirmed frame end, zeroed on loss of lock.
    always_ff @(posedge clk_7x) begin
        if (!clr_n)     word_o <= '0;
        else if (drop)  word_o <= '0;
        else if (load)  word_o <= scattered;
    end

    // R5: no word while unlocked
    p_zero_unlocked_r5: assert property (@(posedge clk_7x) disable iff (!rst_n)
        !locked_o |-> (word_o == '0));

    // R7: shutdown clears outputs on the next edge
    p_shutdown_clear_r7: assert property (@(posedge clk_7x) disable iff (!rst_n)
        !shdn_n |=> (word_o == '0 && !strobe_o && !locked_o));

    // R6: while locked the word only moves with a strobe rise
    p_word_on_strobe_r6: assert property (@(posedge clk_7x) disable iff (!clr_n)
        (locked_o && !$stable(word_o)) |-> $rose(strobe_o));

endmodule

// File: tb/tb_sevenx_deser_rx.sv
// Scoreboard bench: the driver serializes words and queues the ones that
// must appear; the monitor pops on every strobe rise and compares.
module tb_sevenx_deser_rx;
    localparam int unsigned LANES = 4;
    localparam int unsigned BITS  = 7;
    localparam int unsigned W     = LANES * BITS;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         shdn_n = 1'b1;
    logic         fclk = 1'b0;
    logic [3:0]   lanes = '0;
    logic [W-1:0] word;
    logic         strobe;
    logic         locked;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [W-1:0] exp_q[$];
    logic [31:0]  rng = 32'h1234_5678;

    always #10 clk = ~clk;

    sevenx_deser_rx dut (
        .clk_7x   (clk),
        .rst_n    (rst_n),
        .shdn_n   (shdn_n),
        .fclk_i   (fclk),
        .lane_i   (lanes),
        .word_o   (word),
        .strobe_o (strobe),
        .locked_o (locked)
    );

    // R1 serial order: output bit carried by lane l in slot k (0 = first).
    function automatic int ser_bit(input int l, input int k);
        int o0[7] = '{7, 6, 4, 3, 2, 1, 0};
        int o1[7] = '{18, 15, 14, 13, 12, 9, 8};
        int o2[7] = '{26, 25, 24, 22, 21, 20, 19};
        int o3[7] = '{27, 23, 17, 16, 11, 10, 5};
        case (l)
            0:       return o0[k];
            1:       return o1[k];
            2:       return o2[k];
            default: return o3[k];
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // Drive one frame (inputs set, then wait a negedge); optionally queue it.
    task automatic send_frame(input logic [W-1:0] w, input bit good, input bit push);
        if (push) exp_q.push_back(w);
        for (int k = 0; k < 7; k++) begin
            fclk = good ? (k < 4) : (k < 3);
            for (int l = 0; l < 4; l++) lanes[l] = w[ser_bit(l, k)];
            @(negedge clk);
        end
    endtask

    task automatic check_idle(input string tag);
        chk(locked == 1'b0, tag, {27'b0, locked}, '0);
        chk(word == '0, tag, word, '0);
        chk(strobe == 1'b0, tag, {27'b0, strobe}, '0);
    endtask

    function automatic logic [W-1:0] next_rand();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng[W-1:0];
    endfunction

    // Monitor: pop on strobe rise, check strobe shape and gating.
    logic prev_stb = 1'b0;
    int   hi_run = 0;
    int   lo_run = 0;
    bit   lo_valid = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (strobe && !locked)
                chk(1'b0, "R5 strobe while unlocked", {27'b0, strobe}, '0);
            if (strobe && !prev_stb) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected strobe", word, '0);
                end else begin
                    logic [W-1:0] e;
                    e = exp_q.pop_front();
                    chk(word == e, "R1 scattered word at strobe", word, e);
                end
                if (lo_valid)
                    chk(lo_run == 3, "R6 strobe low width", W'(lo_run), W'(3));
                hi_run = 1;
            end else if (strobe) begin
                hi_run++;
            end
            if (!strobe && prev_stb && locked) begin
                chk(hi_run == 4, "R6 strobe high width", W'(hi_run), W'(4));
                lo_valid = 1'b1;
                lo_run = 1;
            end else if (!strobe) begin
                lo_run++;
            end
            if (!locked) lo_valid = 1'b0;
            prev_stb = strobe;
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R8 reset state");
        rst_n = 1'b1;

        // R2/R3: first frame only arms, second frame locks.
        send_frame(28'h5A5_A5A5, 1'b1, 1'b0);
        check_idle("R3 after first frame");
        send_frame(28'h123_4567, 1'b1, 1'b1);
        chk(locked == 1'b1, "R3 lock after second frame", {27'b0, locked}, 28'd1);
        chk(word == 28'h123_4567, "R2 word aligned to frame", word, 28'h123_4567);

        // R1: walking one across every output position.
        for (int b = 0; b < 28; b++) send_frame(W'(1) << b, 1'b1, 1'b1);
        for (int i = 0; i < 12; i++) send_frame(next_rand(), 1'b1, 1'b1);
        send_frame(28'hFFF_FFFF, 1'b1, 1'b1);

        // R4: short frame-clock high drops lock and clears word.
        send_frame(28'hABC_DEF0, 1'b0, 1'b0);
        check_idle("R4 mismatch drops lock");
        send_frame(28'h0F0_F0F0, 1'b1, 1'b0);
        check_idle("R5 resync first frame");
        send_frame(28'h765_4321, 1'b1, 1'b1);
        chk(locked == 1'b1, "R4 relock after search", {27'b0, locked}, 28'd1);
        for (int i = 0; i < 4; i++) send_frame(next_rand(), 1'b1, 1'b1);

        // R7: shutdown with valid traffic keeps everything cleared.
        shdn_n = 1'b0;
        send_frame(28'h111_1111, 1'b1, 1'b0);
        check_idle("R7 shutdown frame 1");
        send_frame(28'h222_2222, 1'b1, 1'b0);
        check_idle("R7 shutdown frame 2");

        // R8: release mid-frame; tail of frame must not frame or output.
        for (int k = 0; k < 7; k++) begin
            if (k == 3) shdn_n = 1'b1;
            fclk = (k < 4);
            lanes = 4'hF;
            @(negedge clk);
        end
        check_idle("R8 partial frame after release");
        send_frame(28'h333_3333, 1'b1, 1'b0);
        check_idle("R8 first full frame after release");
        send_frame(28'h4C4_C4C4, 1'b1, 1'b1);
        chk(locked == 1'b1, "R8 relock after release", {27'b0, locked}, 28'd1);
        for (int i = 0; i < 3; i++) send_frame(next_rand(), 1'b1, 1'b1);

        repeat (8) @(negedge clk);
        chk(exp_q.size() == 0, "R6 every queued word strobed", W'(exp_q.size()), '0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule